// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static RAM Emulator

This block models a byte-wide asynchronous static RAM inside a clocked design. It has two select inputs of opposite polarity, a write strobe and an output-enable strobe, all active as marked. The block takes these inputs on a free-running clock and steers them through a four-state controller. Each state is a row of the control truth table. A write is held in a staging register while its window is open. The byte reaches the array on the first sample in which the window has closed. The bidirectional data bus is split into a write-data input, a read-data output and a drive qualifier, and the drive qualifier feeds an external tristate buffer.

The controller states are: STANDBY (either select is inactive), OFF (selected, no write, output strobe high), READ (selected, no write, output strobe low) and WRITE (selected, write strobe low). Every clock edge moves the controller to the state that the sampled inputs decode to, so any state can follow any other. The transition that leaves WRITE for any other state is named COMMIT, and it writes the staged byte into the array. The address port is always 18 bits wide. The number of locations actually stored is set by `MEM_AW`, and the upper address bits are discarded when fewer locations are stored.

Top module: `sram_emu`

## Requirements
- R1: While reset is asserted and on the first sample after it, `rdata_drv` is 0.
- R2: When `sel_n` is 1 or `sel` is 0 at a sample, `rdata_drv` is 0 after that sample, whatever `wen_n` and `oen_n` are. A write strobe given while deselected does not change the array.
- R3: When a sample sees `sel_n`=0, `sel`=1, `wen_n`=1 and `oen_n`=0, `rdata_drv` is 1 after that sample. `rdata` then shows the byte stored at the sampled address.
- R4: When a sample sees the block selected with `wen_n`=1 and `oen_n`=1, `rdata_drv` is 0 after that sample.
- R5: When a sample sees the block selected with `wen_n`=0, the write window is open and `rdata_drv` is 0 after that sample, for either value of `oen_n`.
- R6: The write window can be closed by `wen_n` rising, by `sel_n` rising or by `sel` falling. Any one of these commits the staged byte to the array on the first sample in which the window is closed.
- R7: When `wdata` or `adr` changes while the window is open, the byte committed is the last `wdata` sampled inside the window, at the last `adr` sampled inside the window.
- R8: Only `adr[MEM_AW-1:0]` selects a location. Two addresses that differ only above bit `MEM_AW-1` refer to the same byte.
- R9: `rdata_drv` is registered. A change of the control inputs between clock edges does not alter it before the next sample.
- R10: Suppose the window closes because `wen_n` rises, and in the same sample the block stays selected with `oen_n`=0 at the same address. Then `rdata` after that sample already shows the byte just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low reset of the controller and the staging register |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| wen_n | input | 1 | Write strobe, active low |
| oen_n | input | 1 | Output-enable strobe, active low |
| adr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data (input half of the data bus) |
| rdata | output | DATA_W | Read data (output half of the data bus) |
| rdata_drv | output | 1 | 1 when the external tristate buffer must drive `rdata` |

## Verification
Every result is due one sample after the control inputs that cause it. This applies to `rdata_drv`, to the read byte in `rdata`, and to a commit, which becomes visible through a read in the sample at which the window closes. The bench changes inputs two nanoseconds after a rising edge. One nanosecond later it confirms that `rdata_drv` still holds its previous value (R9). Two nanoseconds after the next edge it compares both outputs with a byte model updated with that edge's commit rule. Read bytes are compared only at locations the model knows to have been written.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_OFF     = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } sram_state_e;

endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] wdata,
    output logic              drv,
    output logic [ADDR_W-1:0] rd_adr,
    output logic              cmt_en,
    output logic [ADDR_W-1:0] cmt_adr,
    output logic [DATA_W-1:0] cmt_data
);

    sram_state_e state_q;
    sram_state_e state_d;
    logic [ADDR_W-1:0] stage_adr_q;
    logic [DATA_W-1:0] stage_data_q;
    logic [ADDR_W-1:0] rd_adr_q;

    // decode of the sampled control inputs
    always_comb begin
        if (sel_n || !sel)      state_d = ST_STANDBY;
        else if (!wen_n)        state_d = ST_WRITE;
        else if (oen_n)         state_d = ST_OFF;
        else                    state_d = ST_READ;
    end

    // state register and write staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_STANDBY;
            stage_adr_q  <= '0;
            stage_data_q <= '0;
            rd_adr_q     <= '0;
        end else begin
            state_q  <= state_d;
            rd_adr_q <= adr;
            if (state_d == ST_WRITE) begin
                stage_adr_q  <= adr;
                stage_data_q <= wdata;
            end
        end
    end

    // outputs from the current state
    always_comb begin
        drv    = 1'b0;
        cmt_en = 1'b0;
        unique case (state_q)
            ST_STANDBY: drv = 1'b0;
            ST_OFF:     drv = 1'b0;
            ST_READ:    drv = 1'b1;
            ST_WRITE:   cmt_en = rst_n && (state_d != ST_WRITE);
            default:    drv = 1'b0;
        endcase
    end

    assign rd_adr   = rd_adr_q;
    assign cmt_adr  = stage_adr_q;
    assign cmt_data = stage_data_q;

    // R2
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_n || !sel)) |-> !drv);

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n && sel && wen_n && !oen_n)) |-> drv);

    // R4
    oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n && sel && wen_n && oen_n)) |-> !drv);

    // R5
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n && sel && !wen_n)) |-> !drv);

    // R6
    commit_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_en |-> ($past(rst_n) && $past(!sel_n && sel && !wen_n) && !(!sel_n && sel && !wen_n)));

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_adr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_adr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [MEM_AW-1:0] wr_idx;
    logic [MEM_AW-1:0] rd_idx;

    assign wr_idx = MEM_AW'(wr_adr);
    assign rd_idx = MEM_AW'(rd_adr);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

    initial begin
        // R8
        depth_fit_chk: assert (MEM_AW >= 1 && MEM_AW <= ADDR_W);
    end

endmodule

// File: rtl/sram_emu.sv
module sram_emu #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);

    logic              cmt_en;
    logic [ADDR_W-1:0] cmt_adr;
    logic [DATA_W-1:0] cmt_data;
    logic [ADDR_W-1:0] rd_adr;

    sram_emu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel      (sel),
        .wen_n    (wen_n),
        .oen_n    (oen_n),
        .adr      (adr),
        .wdata    (wdata),
        .drv      (rdata_drv),
        .rd_adr   (rd_adr),
        .cmt_en   (cmt_en),
        .cmt_adr  (cmt_adr),
        .cmt_data (cmt_data)
    );

    sram_emu_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) array_i (
        .clk     (clk),
        .wr_en   (cmt_en),
        .wr_adr  (cmt_adr),
        .wr_data (cmt_data),
        .rd_adr  (rd_adr),
        .rd_data (rdata)
    );

endmodule

// File: tb/sram_emu_tb.sv
module sram_emu_tb_top;

    localparam int AW  = 18;
    localparam int DW  = 8;
    localparam int MAW = 6;
    localparam int NLOC = 1 << MAW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          sel = 1'b0;
    logic          wen_n = 1'b1;
    logic          oen_n = 1'b1;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    logic [DW-1:0]  model [NLOC];
    bit             vld [NLOC];
    bit             pend = 0;
    logic [MAW-1:0] padr;
    logic [DW-1:0]  pdata;
    bit             prev_oe = 0;

    sram_emu #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wen_n(wen_n),
        .oen_n(oen_n), .adr(adr), .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_drive(input logic cn, input logic c, input logic wn, input logic on);
        return !cn && c && wn && !on;
    endfunction

    function automatic bit window(input logic cn, input logic c, input logic wn);
        return !cn && c && !wn;
    endfunction

    // one sample: drive, check R9 before the edge, update model, check after
    task automatic apply(input logic cn, input logic c, input logic wn, input logic on,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        bit eo;
        logic [MAW-1:0] fa;
        sel_n = cn; sel = c; wen_n = wn; oen_n = on; adr = a; wdata = d;
        #1;
        chk(rdata_drv === prev_oe, "R9", "drive before edge", int'(rdata_drv), int'(prev_oe));
        @(posedge clk);
        fa = a[MAW-1:0];
        if (pend && !window(cn, c, wn)) begin
            model[padr] = pdata;
            vld[padr] = 1;
            pend = 0;
        end
        if (window(cn, c, wn)) begin
            pend = 1; padr = fa; pdata = d;
        end
        eo = exp_drive(cn, c, wn, on);
        #2;
        chk(rdata_drv === eo, tag, "drive", int'(rdata_drv), int'(eo));
        if (eo && vld[fa])
            chk(rdata === model[fa], tag, "read byte", int'(rdata), int'(model[fa]));
        prev_oe = eo;
    endtask

    task automatic expect_byte(input logic [DW-1:0] e, input string tag);
        chk(rdata_drv === 1'b1 && rdata === e, tag, "directed byte", int'(rdata), int'(e));
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24601));
        for (int i = 0; i < NLOC; i++) vld[i] = 0;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(rdata_drv === 1'b0, "R1", "drive in reset", int'(rdata_drv), 0);
        rst_n = 1'b1;
        apply(1, 0, 1, 1, 0, 0, "R1");

        // R5 + R10: write 0x05, oe low then high, close by wen_n with read
        apply(0, 1, 0, 0, 18'h05, 8'hA5, "R5");
        apply(0, 1, 0, 1, 18'h05, 8'hA5, "R5");
        apply(0, 1, 1, 0, 18'h05, 8'h00, "R10");
        expect_byte(8'hA5, "R10");

        // R6: close by sel_n rising
        apply(0, 1, 0, 1, 18'h09, 8'h3C, "R5");
        apply(1, 1, 0, 0, 18'h09, 8'hFF, "R2");
        apply(0, 1, 1, 0, 18'h09, 8'h00, "R6");
        expect_byte(8'h3C, "R6");

        // R6: close by sel falling
        apply(0, 1, 0, 0, 18'h11, 8'h11, "R5");
        apply(0, 0, 0, 0, 18'h11, 8'hEE, "R2");
        apply(0, 1, 1, 0, 18'h11, 8'h00, "R6");
        expect_byte(8'h11, "R6");

        // R7: data and address change inside the window
        apply(0, 1, 0, 1, 18'h13, 8'h01, "R7");
        apply(0, 1, 0, 1, 18'h14, 8'h02, "R7");
        apply(0, 1, 0, 1, 18'h14, 8'h7E, "R7");
        apply(0, 1, 1, 0, 18'h14, 8'h00, "R7");
        expect_byte(8'h7E, "R7");

        // R4: output disabled
        apply(0, 1, 1, 1, 18'h05, 8'h00, "R4");

        // R2: write strobes while deselected do not write
        apply(1, 1, 0, 0, 18'h05, 8'h00, "R2");
        apply(0, 0, 0, 0, 18'h05, 8'h00, "R2");
        apply(1, 0, 0, 1, 18'h05, 8'h00, "R2");
        apply(0, 1, 1, 0, 18'h05, 8'h00, "R2");
        expect_byte(8'hA5, "R2");

        // R8: aliasing of upper address bits
        apply(0, 1, 0, 1, 18'h30023, 8'h5A, "R8");
        apply(0, 1, 1, 1, 18'h30023, 8'h00, "R8");
        apply(0, 1, 1, 0, 18'h00023, 8'h00, "R8");
        expect_byte(8'h5A, "R8");
        apply(0, 1, 1, 0, 18'h10023, 8'h00, "R8");
        expect_byte(8'h5A, "R8");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic cn, c, wn, on;
            logic [AW-1:0] a;
            cn = ($urandom % 8) == 0;
            c  = ($urandom % 8) != 0;
            wn = ($urandom % 3) != 0;
            on = ($urandom % 4) == 0;
            a  = {AW'($urandom % 4) << MAW, 2'b00, 4'($urandom)};
            a  = a & {AW{1'b1}};
            apply(cn, c, wn, on, a, 8'($urandom), "R3");
        end

        // R1: reset again drops drive
        apply(0, 1, 1, 0, 18'h05, 8'h00, "R3");
        rst_n = 1'b0;
        #1;
        chk(rdata_drv === 1'b0, "R1", "drive in reset", int'(rdata_drv), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule